// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in seven packed-BCD registers: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A free-running prescaler outside the block supplies a single-cycle enable, `sub_tick`, at a fixed rate of `TICKS_PER_SEC` pulses per second. An internal sub-second phase counter turns those pulses into one-second steps. Each step ripples carries from seconds up through the year. The month length depends on the month and on whether the year is a leap year.

Software presets any field through a one-cycle write port. It reads any field through a combinational read port addressed by register number. The hour register carries its own format bit: in 24-hour mode it counts 00 to 23; in 12-hour mode it counts 12, 01 … 11 with an AM/PM flag. The top bit of the seconds register freezes the whole clock. After reset the clock is frozen until software clears that bit.

Top module: `bcdcal_top`

## Requirements
- R1: After reset the registers read 0x80 (address 0, halted, 00 s), 0x00 (minutes), 0x00 (hours, 24-hour mode), 0x01 (weekday), 0x01 (date), 0x01 (month), 0x00 (year).
- R2: Bit 7 of register 0 is the halt flag. While it is 1, no sub-second pulse changes any time or calendar register.
- R3: While running, the seconds register advances by one every `TICKS_PER_SEC` pulses of `sub_tick`. Seconds and minutes count BCD 00 to 59, and a rollover from 59 carries into the next field.
- R4: With hour-register bit 6 at 0 (24-hour mode), bits 5:0 count BCD 00 to 23. Bit 5 is the upper tens-of-hours bit. A step from 23:59:59 gives 00:00:00 and advances the day.
- R5: With bit 6 at 1 (12-hour mode), bit 5 is the PM flag (1 = PM) and bits 4:0 count BCD 12, 01 … 11. The step 11→12 flips the flag. The day advances only on the PM 11:59:59 → AM 12:00:00 step.
- R6: The weekday (address 3) counts 1 to 7 and returns to 1 only at the day change.
- R7: The date (address 4) returns to 01 after the last day of the month. That last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. For month 02 it is 29 when the BCD year is a multiple of four (00 included) and 28 otherwise.
- R8: The month (address 5) counts 01 to 12. The step after day 31 of month 12 sets month 01 and advances the year (address 6), which wraps from 99 to 00.
- R9: A write to register 0 clears the sub-second phase, so the next seconds step comes exactly `TICKS_PER_SEC` pulses after the write.
- R10: In a cycle with `wr_en` high, a pulse on `sub_tick` neither advances time nor moves the sub-second phase. A written field keeps only its defined bits: 7 for seconds, minutes and hours, 3 for weekday, 6 for date, 5 for month and 8 for year. The bits above them read 0.
- R11: Addresses 0 to 6 read seconds, minutes, hours, weekday, date, month and year in that order. Address 7 reads 0x00, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One-cycle prescaler pulse, `TICKS_PER_SEC` per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register number for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register number for the read |
| rd_data | output | 8 | Combinational read data |

## Verification
The bench walks the clock across every boundary where a carry changes shape:
- the ends of 30- and 31-day months;
- February in leap and non-leap years, including year 00;
- New Year's Eve of year 99;
- the 12-hour noon and midnight steps and the 24-hour 23→00 step.

A wrong month-length table or leap rule would land the date on 29, 31 or 01 one day early or late. A 12-hour counter that flipped the flag at 12→01, or advanced the date at noon, would show up in the hour and date bytes.

Directed tests cover the remaining rules. They check that a halted clock stays frozen across many pulses and that a seconds write realigns the next step to a full second. They also check that a pulse coinciding with a write is dropped rather than applied late. A design that ignored any of these would end the test one second off.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

   localparam int ADDR_W     = 3;
   localparam int NUM_FIELDS = 7;

   localparam int ADR_SEC   = 0;
   localparam int ADR_MIN   = 1;
   localparam int ADR_HOUR  = 2;
   localparam int ADR_WDAY  = 3;
   localparam int ADR_DATE  = 4;
   localparam int ADR_MONTH = 5;
   localparam int ADR_YEAR  = 6;

   localparam int SEC_W   = 7;
   localparam int MIN_W   = 7;
   localparam int HOUR_W  = 7;
   localparam int WDAY_W  = 3;
   localparam int DATE_W  = 6;
   localparam int MONTH_W = 5;
   localparam int YEAR_W  = 8;

   // Last valid day of a month, in BCD; leap years are BCD years divisible by four.
   function automatic logic [DATE_W-1:0] month_last(input logic [MONTH_W-1:0] mon,
                                                    input logic [YEAR_W-1:0]  yr);
      int yv;
      logic [DATE_W-1:0] res;
      yv = int'(yr[7:4]) * 10 + int'(yr[3:0]);
      case (mon)
         5'h02:                      res = ((yv % 4) == 0) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: res = 6'h30;
         default:                    res = 6'h31;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/cal_subsec.sv
module cal_subsec #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic clr,
   output logic adv
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   initial begin
      assert (DIV >= 1) else $error("cal_subsec: DIV must be at least 1");
   end

   logic [PW-1:0] ph;

   assign adv = tick && run && (ph == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ph <= '0;
      else if (clr)          ph <= '0;
      else if (tick && run)  ph <= (ph == LAST) ? '0 : ph + 1'b1;
   end

   assert_phase_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ph == '0));

endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
   parameter int W   = 7,
   parameter int LO  = 'h00,
   parameter int HI  = 'h59,
   parameter int RST = 'h00
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q,
   output logic         carry
);
   localparam logic [W-1:0] LO_V  = W'(LO);
   localparam logic [W-1:0] HI_V  = W'(HI);
   localparam logic [W-1:0] RST_V = W'(RST);

   initial begin
      assert (W >= 1 && W <= 8) else $error("cal_bcd_field: W out of range");
   end

   logic [W-1:0] q_inc;

   generate
      if (W > 4) begin : g_two_digit
         always_comb begin
            if (q[3:0] == 4'h9) q_inc = {q[W-1:4] + 1'b1, 4'h0};
            else                q_inc = {q[W-1:4], q[3:0] + 4'h1};
         end
      end else begin : g_one_digit
         always_comb q_inc = q + 1'b1;
      end
   endgenerate

   assign carry = inc && (q == HI_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_V;
      else if (ld)  q <= ld_val;
      else if (inc) q <= (q == HI_V) ? LO_V : q_inc;
   end

   // Also guards the weekday (R6) and month/year (R8) instances.
   assert_field_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && q == HI_V) |=> (q == LO_V));

endmodule

// File: rtl/cal_hour_field.sv
module cal_hour_field (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld,
   input  logic [6:0] ld_val,
   output logic [6:0] q,
   output logic       carry
);
   logic       mode12;
   logic       pm;
   logic [4:0] h12;
   logic [5:0] h24;
   logic [4:0] h12_inc;
   logic [5:0] h24_inc;

   assign mode12 = q[6];
   assign pm     = q[5];
   assign h12    = q[4:0];
   assign h24    = q[5:0];

   always_comb begin
      if (h12[3:0] == 4'h9) h12_inc = 5'h10;
      else                  h12_inc = {h12[4], h12[3:0] + 4'h1};
      if (h24[3:0] == 4'h9) h24_inc = {h24[5:4] + 2'd1, 4'h0};
      else                  h24_inc = {h24[5:4], h24[3:0] + 4'h1};
   end

   assign carry = inc && (mode12 ? (pm && h12 == 5'h11) : (h24 == 6'h23));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 7'h00;
      else if (ld) q <= ld_val;
      else if (inc) begin
         if (mode12) begin
            if (h12 == 5'h12)      q <= {1'b1, pm, 5'h01};
            else if (h12 == 5'h11) q <= {1'b1, ~pm, 5'h12};
            else                   q <= {1'b1, pm, h12_inc};
         end else begin
            if (h24 == 6'h23) q <= 7'h00;
            else              q <= {1'b0, h24_inc};
         end
      end
   end

   assert_pm_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && mode12 && h12 == 5'h11) |=> (q[5] != $past(q[5]) && q[4:0] == 5'h12));

   assert_midnight_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && !mode12 && h24 == 6'h23) |=> (q == 7'h00));

endmodule

// File: rtl/cal_date_field.sv
module cal_date_field (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld,
   input  logic [5:0] ld_val,
   input  logic [5:0] last,
   output logic [5:0] q,
   output logic       carry
);
   logic [5:0] q_inc;

   always_comb begin
      if (q[3:0] == 4'h9) q_inc = {q[5:4] + 2'd1, 4'h0};
      else                q_inc = {q[5:4], q[3:0] + 4'h1};
   end

   assign carry = inc && (q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 6'h01;
      else if (ld)  q <= ld_val;
      else if (inc) q <= (q >= last) ? 6'h01 : q_inc;
   end

   assert_date_roll_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && q >= last) |=> (q == 6'h01));

endmodule

// File: rtl/bcdcal_top.sv
module bcdcal_top
   import bcdcal_pkg::*;
#(
   parameter int TICKS_PER_SEC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   logic                  halt_q;
   logic [NUM_FIELDS-1:0] ld;
   logic                  adv;
   logic [SEC_W-1:0]      sec_q;
   logic [MIN_W-1:0]      min_q;
   logic [HOUR_W-1:0]     hour_q;
   logic [WDAY_W-1:0]     wday_q;
   logic [DATE_W-1:0]     date_q;
   logic [MONTH_W-1:0]    month_q;
   logic [YEAR_W-1:0]     year_q;
   logic                  sec_c, min_c, day_c, wday_c, date_c, mon_c, yr_c;
   logic [DATE_W-1:0]     last_day;

   generate
      for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_ld
         assign ld[k] = wr_en && (wr_addr == ADDR_W'(k));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          halt_q <= 1'b1;
      else if (ld[ADR_SEC]) halt_q <= wr_data[7];
   end

   cal_subsec #(.DIV(TICKS_PER_SEC)) u_phase (
      .clk(clk), .rst_n(rst_n), .tick(sub_tick),
      .run(!halt_q && !wr_en), .clr(ld[ADR_SEC]), .adv(adv));

   cal_bcd_field #(.W(SEC_W), .LO('h00), .HI('h59), .RST('h00)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(adv), .ld(ld[ADR_SEC]),
      .ld_val(wr_data[SEC_W-1:0]), .q(sec_q), .carry(sec_c));

   cal_bcd_field #(.W(MIN_W), .LO('h00), .HI('h59), .RST('h00)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(sec_c), .ld(ld[ADR_MIN]),
      .ld_val(wr_data[MIN_W-1:0]), .q(min_q), .carry(min_c));

   cal_hour_field u_hour (
      .clk(clk), .rst_n(rst_n), .inc(min_c), .ld(ld[ADR_HOUR]),
      .ld_val(wr_data[HOUR_W-1:0]), .q(hour_q), .carry(day_c));

   cal_bcd_field #(.W(WDAY_W), .LO(1), .HI(7), .RST(1)) u_wday (
      .clk(clk), .rst_n(rst_n), .inc(day_c), .ld(ld[ADR_WDAY]),
      .ld_val(wr_data[WDAY_W-1:0]), .q(wday_q), .carry(wday_c));

   assign last_day = month_last(month_q, year_q);

   cal_date_field u_date (
      .clk(clk), .rst_n(rst_n), .inc(day_c), .ld(ld[ADR_DATE]),
      .ld_val(wr_data[DATE_W-1:0]), .last(last_day), .q(date_q), .carry(date_c));

   cal_bcd_field #(.W(MONTH_W), .LO('h01), .HI('h12), .RST('h01)) u_month (
      .clk(clk), .rst_n(rst_n), .inc(date_c), .ld(ld[ADR_MONTH]),
      .ld_val(wr_data[MONTH_W-1:0]), .q(month_q), .carry(mon_c));

   cal_bcd_field #(.W(YEAR_W), .LO('h00), .HI('h99), .RST('h00)) u_year (
      .clk(clk), .rst_n(rst_n), .inc(mon_c), .ld(ld[ADR_YEAR]),
      .ld_val(wr_data[YEAR_W-1:0]), .q(year_q), .carry(yr_c));

   always_comb begin
      case (rd_addr)
         ADDR_W'(ADR_SEC):   rd_data = {halt_q, sec_q};
         ADDR_W'(ADR_MIN):   rd_data = {1'b0, min_q};
         ADDR_W'(ADR_HOUR):  rd_data = {1'b0, hour_q};
         ADDR_W'(ADR_WDAY):  rd_data = {5'b0, wday_q};
         ADDR_W'(ADR_DATE):  rd_data = {2'b0, date_q};
         ADDR_W'(ADR_MONTH): rd_data = {3'b0, month_q};
         ADDR_W'(ADR_YEAR):  rd_data = year_q;
         default:            rd_data = 8'h00;
      endcase
   end

   assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !wr_en) |=> $stable({sec_q, min_q, hour_q, wday_q, date_q, month_q, year_q}));

   assert_write_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !adv);

   assert_wday_midnight_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wday_c |=> (hour_q[6] ? (hour_q[5:0] == 6'h12) : (hour_q[5:0] == 6'h00)));

   assert_year_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      yr_c |=> (month_q == 5'h01 && year_q == 8'h00));

endmodule

// File: tb/bcdcal_top_tb.sv
module bcdcal_top_tb;
   localparam int DIV = 4;
   localparam int NV  = 17;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sub_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bcdcal_top #(.TICKS_PER_SEC(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

   // {start sec,min,hour,wday,date,month,year ; seconds to run ; expected ; requirement}
   typedef logic [135:0] vec_t;
   localparam vec_t VECS [NV] = '{
      {56'h00_00_00_01_01_01_00, 16'd5,  56'h05_00_00_01_01_01_00, 8'd3},  // R3 plain count
      {56'h58_59_00_01_01_01_00, 16'd3,  56'h01_00_01_01_01_01_00, 8'd3},  // R3 minute/hour carry
      {56'h59_59_23_07_15_03_21, 16'd1,  56'h00_00_00_01_16_03_21, 8'd4},  // R4 midnight, R6 wrap
      {56'h59_59_23_03_30_04_21, 16'd1,  56'h00_00_00_04_01_05_21, 8'd7},  // R7 30-day month
      {56'h59_59_23_03_31_01_21, 16'd1,  56'h00_00_00_04_01_02_21, 8'd7},  // R7 31-day month
      {56'h59_59_23_03_28_02_23, 16'd1,  56'h00_00_00_04_01_03_23, 8'd7},  // R7 Feb common year
      {56'h59_59_23_03_28_02_24, 16'd1,  56'h00_00_00_04_29_02_24, 8'd7},  // R7 Feb leap 28->29
      {56'h59_59_23_03_29_02_24, 16'd1,  56'h00_00_00_04_01_03_24, 8'd7},  // R7 Feb leap end
      {56'h59_59_23_05_31_12_99, 16'd1,  56'h00_00_00_06_01_01_00, 8'd8},  // R8 year wrap
      {56'h59_59_51_02_10_06_21, 16'd1,  56'h00_00_72_02_10_06_21, 8'd5},  // R5 AM 11 -> PM 12
      {56'h59_59_71_02_10_06_21, 16'd1,  56'h00_00_52_03_11_06_21, 8'd5},  // R5 PM 11 -> AM 12
      {56'h59_59_52_02_10_06_21, 16'd1,  56'h00_00_41_02_10_06_21, 8'd5},  // R5 12 -> 01
      {56'h59_59_09_02_10_06_21, 16'd1,  56'h00_00_10_02_10_06_21, 8'd4},  // R4 09 -> 10
      {56'h59_59_23_06_29_02_00, 16'd1,  56'h00_00_00_07_01_03_00, 8'd7},  // R7 year 00 leap
      {56'h00_00_00_01_01_01_00, 16'd70, 56'h10_01_00_01_01_01_00, 8'd3},  // R3 seventy seconds
      {56'h59_59_23_07_30_09_21, 16'd1,  56'h00_00_00_01_01_10_21, 8'd6},  // R6 wrap, 30-day
      {56'h59_59_23_01_30_12_21, 16'd1,  56'h00_00_00_02_31_12_21, 8'd7}   // R7 Dec 30 -> 31
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sub_tick = 1'b1;
         @(negedge clk); sub_tick = 1'b0;
      end
   endtask

   task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic read_all(output logic [55:0] v);
      logic [7:0] b;
      for (int k = 0; k < 7; k++) begin
         read_reg(3'(k), b);
         v[55-8*k -: 8] = b;
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [55:0] snap;
      logic [55:0] snap2;
      logic [7:0]  b;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      read_all(snap);
      check("R1 reset state", 64'(snap), 64'h80_00_00_01_01_01_00);
      // R11 unused address reads zero
      read_reg(3'd7, b);
      check("R11 address 7 read", 64'(b), 64'h00);

      // R2 halted after reset: pulses change nothing
      pulse(3 * DIV);
      read_all(snap2);
      check("R2 halted after reset", 64'(snap2), 64'(snap));
      write_reg(3'd0, 8'hB0);
      pulse(3 * DIV);
      read_reg(3'd0, b);
      check("R2 halted with preset seconds", 64'(b), 64'hB0);
      write_reg(3'd0, 8'h30);
      pulse(DIV);
      read_reg(3'd0, b);
      check("R3 running after halt clear", 64'(b), 64'h31);

      // R9 seconds write realigns the phase
      write_reg(3'd0, 8'h00);
      pulse(DIV - 1);
      write_reg(3'd0, 8'h10);
      pulse(DIV - 1);
      read_reg(3'd0, b);
      check("R9 no step before full second", 64'(b), 64'h10);
      pulse(1);
      read_reg(3'd0, b);
      check("R9 step after full second", 64'(b), 64'h11);

      // R10 pulse coinciding with a write is dropped
      pulse(DIV - 1);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h05; sub_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; sub_tick = 1'b0;
      read_reg(3'd0, b);
      check("R10 seconds held on write cycle", 64'(b), 64'h11);
      read_reg(3'd1, b);
      check("R10 minute written", 64'(b), 64'h05);
      pulse(1);
      read_reg(3'd0, b);
      check("R10 phase kept across write", 64'(b), 64'h12);

      // R10 masking of undefined bits
      write_reg(3'd3, 8'hFF);
      read_reg(3'd3, b);
      check("R10 weekday mask", 64'(b), 64'h07);
      write_reg(3'd4, 8'hFF);
      read_reg(3'd4, b);
      check("R10 date mask", 64'(b), 64'h3F);
      write_reg(3'd5, 8'hFF);
      read_reg(3'd5, b);
      check("R10 month mask", 64'(b), 64'h1F);

      // R11 write to address 7 has no effect
      write_reg(3'd0, 8'h80);
      read_all(snap);
      write_reg(3'd7, 8'hAA);
      read_all(snap2);
      check("R11 address 7 write ignored", 64'(snap2), 64'(snap));
      read_reg(3'd7, b);
      check("R11 address 7 still zero", 64'(b), 64'h00);

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         vec_t        v;
         logic [55:0] init;
         logic [55:0] expv;
         logic [55:0] got;
         int          secs;
         v    = VECS[i];
         init = v[135:80];
         secs = int'(v[79:64]);
         expv = v[63:8];
         for (int k = 1; k < 7; k++) write_reg(3'(k), init[55-8*k -: 8]);
         write_reg(3'd0, init[55:48]);
         pulse(secs * DIV);
         read_all(got);
         check($sformatf("R%0d vector %0d", v[7:0], i), 64'(got), 64'(expv));
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule